// File: doc/BRIEF.md
# Scaled-Index Store Formatter

This block turns one decoded integer store request into one memory write. The effective address is a base operand plus an index value scaled by a left shift of one to four bit positions. A base register numbered zero means a base of zero, except in the base-update forms, which always add the register contents. The block places the store field on a 64-bit lane bus and marks the written lanes with byte strobes. The field holds the low 1, 2, 4 or 8 bytes of the source value, in big-endian order or in byte-reversed order. For the base-update forms, the block also returns the effective address so that it can be written back into the base register.

Requests enter on a valid/ready pair (`req_valid`/`req_ready`). The block holds one request at a time. `req_ready` is high only while the output register is empty. An accepted request appears on the memory side in the next cycle, and it stays there unchanged until `mem_ready` is high at a clock edge.

Some requests cannot be issued: the illegal encodings, and accesses that spill past the end of their aligned doubleword. The block still accepts such a request. It then raises a one-cycle error pulse in place of a write, and it performs neither a memory write nor a writeback.

Top module: `scaled_store_unit`

## Requirements
- R1: The effective address is `base_op + (req_index << (req_shift + 1))`, computed modulo 2^64, where `req_shift` is a 2-bit field.
- R2: `base_op` is zero when `req_base_is_r0` is 1 and `req_update` is 0. Otherwise `base_op` is `req_base`.
- R3: `req_size` codes 0, 1, 2 and 3 select 1, 2, 4 and 8 bytes. `mem_addr` is the effective address with bits [2:0] cleared. Strobe bit i is set exactly for the lanes i from `off` to `off+n-1`, where `off` is the effective address bits [2:0] and n is the access size in bytes.
- R4: Lane i of `mem_wdata` (bits 8i+7..8i) is the byte written at `mem_addr + i`. When `req_brev` is 0, the byte at `EA + k` is source byte `n-1-k` (byte 0 is bits 7:0). This is big-endian order.
- R5: When `req_brev` is 1, the byte at `EA + k` is source byte k, so the least-significant source byte goes to the lowest address.
- R6: A request is invalid in three cases: `req_update` with `req_base_is_r0`, `req_brev` with `req_update`, or `req_brev` with size code 0. An invalid request produces `err_valid` with `err_invalid` set, and it gives no memory write and no writeback.
- R7: A request with `off + n > 8` produces `err_valid` with `err_misaligned` set, and it gives no memory write and no writeback.
- R8: `req_ready` is high only while no request is held. A request accepted at a clock edge drives `mem_valid` or `err_valid` in the next cycle. While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr`, `mem_wdata` and `mem_strb` stay stable.
- R9: For update forms, `wb_valid` is high exactly in the cycle where both `mem_valid` and `mem_ready` are high, and `wb_addr` then equals the effective address. For non-update forms, `wb_valid` stays low.
- R10: `err_valid` lasts one cycle, and `req_ready` is high again in the cycle after it.
- R11: Lanes of `mem_wdata` that have no strobe set are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted |
| req_base | input | 64 | Base register contents |
| req_index | input | 64 | Index register contents |
| req_src | input | 64 | Source register contents |
| req_shift | input | 2 | Index shift field; scale is shift+1 bit positions |
| req_size | input | 2 | Access size code (0:1, 1:2, 2:4, 3:8 bytes) |
| req_brev | input | 1 | Byte-reversed store |
| req_update | input | 1 | Base-update form |
| req_base_is_r0 | input | 1 | Base register number is zero |
| mem_valid | output | 1 | Memory write offered |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | 64 | Doubleword-aligned write address |
| mem_wdata | output | 64 | Write data by byte lane |
| mem_strb | output | 8 | Byte-lane strobes |
| wb_valid | output | 1 | Base-register writeback strobe |
| wb_addr | output | 64 | Effective address for writeback |
| err_valid | output | 1 | Rejected request pulse |
| err_invalid | output | 1 | Rejected for an illegal encoding |
| err_misaligned | output | 1 | Rejected for crossing a doubleword |

## Verification
Every result is due one register stage after acceptance. Either `mem_valid` with the write, or `err_valid` with its cause, is present in the cycle after the accepting edge. The writeback strobe is due combinationally in the cycle where the write completes. The driver pushes each reference result at acceptance. The monitor samples on the falling edge and pops an item only in a cycle where `mem_valid` and `mem_ready` are both high, or where `err_valid` is high, so that stalls of any length never shift a comparison. A random stall pattern on `mem_ready` also lets the monitor check that a held write stays unchanged from one stalled cycle to the next.

// File: rtl/ssu_pkg.sv
package ssu_pkg;
  localparam int unsigned SSU_AW  = 64;
  localparam int unsigned SSU_DW  = 64;
  localparam int unsigned SSU_SHW = 2;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } ssu_size_e;

  // byte count of an access, width w
  function automatic logic [4:0] ssu_nbytes(input ssu_size_e s);
    return 5'd1 << s;
  endfunction
endpackage

// File: rtl/ssu_agen.sv
module ssu_agen #(
  parameter int unsigned AW  = 64,
  parameter int unsigned SHW = 2
) (
  input  logic [AW-1:0]  base,
  input  logic [AW-1:0]  index,
  input  logic [SHW-1:0] shift,
  input  logic           base_zero,
  output logic [AW-1:0]  ea
);
  localparam int unsigned AMT_W = SHW + 1;

  logic [AW-1:0]    base_op;
  logic [AMT_W-1:0] amt;

  always_comb begin
    base_op = base_zero ? '0 : base;
    amt     = {1'b0, shift} + AMT_W'(1);
    ea      = base_op + (index << amt);
  end
endmodule

// File: rtl/ssu_check.sv
module ssu_check #(
  parameter int unsigned LANES = 8,
  parameter int unsigned OFF_W = $clog2(LANES)
) (
  input  ssu_pkg::ssu_size_e size,
  input  logic               brev,
  input  logic               update,
  input  logic               base_is_r0,
  input  logic [OFF_W-1:0]   offset,
  output logic               invalid,
  output logic               misaligned,
  output logic [LANES-1:0]   strb
);
  localparam int unsigned CW = OFF_W + 2;

  logic [CW-1:0] nb;
  logic [CW-1:0] reach;

  always_comb begin
    nb         = CW'(ssu_pkg::ssu_nbytes(size));
    reach      = CW'(offset) + nb;
    misaligned = reach > CW'(LANES);
    invalid    = (update && base_is_r0) || (brev && update) ||
                 (brev && size == ssu_pkg::SZ_BYTE);
  end

  for (genvar gi = 0; gi < LANES; gi++) begin : g_strb
    assign strb[gi] = (CW'(gi) >= CW'(offset)) && (CW'(gi) < reach);
  end
endmodule

// File: rtl/ssu_lane_fmt.sv
module ssu_lane_fmt #(
  parameter int unsigned LANES = 8,
  parameter int unsigned OFF_W = $clog2(LANES)
) (
  input  logic [8*LANES-1:0] src,
  input  ssu_pkg::ssu_size_e size,
  input  logic               brev,
  input  logic [OFF_W-1:0]   offset,
  output logic [8*LANES-1:0] wdata
);
  localparam int unsigned KW = OFF_W + 2;

  logic [KW-1:0] nb;
  assign nb = KW'(ssu_pkg::ssu_nbytes(size));

  for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
    logic [KW-1:0] k;
    logic [KW-1:0] pick;
    logic [7:0]    lane_b;
    always_comb begin
      // position of this lane inside the stored field (wraps high when before it)
      k      = KW'(gi) - KW'(offset);
      pick   = brev ? k : (nb - KW'(1) - k);
      lane_b = 8'h00;
      if (k < nb) lane_b = src[8*pick[OFF_W-1:0] +: 8];
    end
    assign wdata[8*gi +: 8] = lane_b;
  end
endmodule

// File: rtl/scaled_store_unit.sv
module scaled_store_unit #(
  parameter int unsigned AW  = ssu_pkg::SSU_AW,
  parameter int unsigned DW  = ssu_pkg::SSU_DW,
  parameter int unsigned SHW = ssu_pkg::SSU_SHW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_base,
  input  logic [AW-1:0] req_index,
  input  logic [DW-1:0] req_src,
  input  logic [SHW-1:0] req_shift,
  input  logic [1:0]    req_size,
  input  logic          req_brev,
  input  logic          req_update,
  input  logic          req_base_is_r0,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic [DW/8-1:0] mem_strb,
  output logic          wb_valid,
  output logic [AW-1:0] wb_addr,
  output logic          err_valid,
  output logic          err_invalid,
  output logic          err_misaligned
);
  localparam int unsigned LANES = DW / 8;
  localparam int unsigned OFF_W = $clog2(LANES);

  ssu_pkg::ssu_size_e size_e;
  assign size_e = ssu_pkg::ssu_size_e'(req_size);

  logic [AW-1:0]    ea;
  logic [LANES-1:0] strb_c;
  logic [DW-1:0]    wdata_c;
  logic             inv_c, mis_c;

  ssu_agen #(.AW(AW), .SHW(SHW)) i_agen (
    .base      (req_base),
    .index     (req_index),
    .shift     (req_shift),
    .base_zero (req_base_is_r0 && !req_update),
    .ea        (ea)
  );

  ssu_check #(.LANES(LANES), .OFF_W(OFF_W)) i_check (
    .size       (size_e),
    .brev       (req_brev),
    .update     (req_update),
    .base_is_r0 (req_base_is_r0),
    .offset     (ea[OFF_W-1:0]),
    .invalid    (inv_c),
    .misaligned (mis_c),
    .strb       (strb_c)
  );

  ssu_lane_fmt #(.LANES(LANES), .OFF_W(OFF_W)) i_fmt (
    .src    (req_src),
    .size   (size_e),
    .brev   (req_brev),
    .offset (ea[OFF_W-1:0]),
    .wdata  (wdata_c)
  );

  // single output stage
  logic             q_valid, q_err, q_wb, q_inv, q_mis;
  logic [AW-1:0]    q_ea;
  logic [DW-1:0]    q_data;
  logic [LANES-1:0] q_strb;
  logic             accept;

  assign req_ready = !q_valid && !q_err;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_err   <= 1'b0;
      q_wb    <= 1'b0;
      q_inv   <= 1'b0;
      q_mis   <= 1'b0;
      q_ea    <= '0;
      q_data  <= '0;
      q_strb  <= '0;
    end else if (accept) begin
      q_valid <= !(inv_c || mis_c);
      q_err   <= inv_c || mis_c;
      q_wb    <= req_update;
      q_inv   <= inv_c;
      q_mis   <= mis_c;
      q_ea    <= ea;
      q_data  <= wdata_c;
      q_strb  <= strb_c;
    end else begin
      q_err <= 1'b0;
      if (q_valid && mem_ready) q_valid <= 1'b0;
    end
  end

  assign mem_valid      = q_valid;
  assign mem_addr       = {q_ea[AW-1:OFF_W], OFF_W'(0)};
  assign mem_wdata      = q_data;
  assign mem_strb       = q_strb;
  assign wb_valid       = q_valid && mem_ready && q_wb;
  assign wb_addr        = q_ea;
  assign err_valid      = q_err;
  assign err_invalid    = q_err && q_inv;
  assign err_misaligned = q_err && q_mis;

  p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
                                   $stable(mem_wdata) && $stable(mem_strb)));

  p_busy_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid || err_valid) |-> !req_ready);

  p_result_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (mem_valid || err_valid));

  p_err_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |=> (!err_valid && req_ready));

  p_err_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> (!mem_valid && !wb_valid));

  p_wb_on_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (mem_valid && mem_ready));

  p_strb_size_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> ($countones(mem_strb) == 1 || $countones(mem_strb) == 2 ||
                   $countones(mem_strb) == 4 || $countones(mem_strb) == 8));
endmodule

// File: tb/test_scaled_store_unit.sv
module test_scaled_store_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_base = '0, req_index = '0, req_src = '0;
  logic [1:0]  req_shift = '0, req_size = '0;
  logic        req_brev = 1'b0, req_update = 1'b0, req_base_is_r0 = 1'b0;
  logic        mem_valid, mem_ready = 1'b1;
  logic [63:0] mem_addr, mem_wdata, wb_addr;
  logic [7:0]  mem_strb;
  logic        wb_valid, err_valid, err_invalid, err_misaligned;

  always #10 clk = ~clk;

  scaled_store_unit i_scaled_store_unit (.*);

  typedef struct {
    logic        is_err;
    logic [63:0] addr;
    logic [63:0] data;
    logic [7:0]  strb;
    logic        wb;
    logic [63:0] ea;
    logic        inv;
    logic        mis;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0, n_fail = 0;
  logic stall_en = 1'b0;
  logic done = 1'b0;

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [63:0] b, input logic [63:0] x,
                                 input logic [63:0] s, input logic [1:0] sh,
                                 input logic [1:0] sz, input logic rv,
                                 input logic up, input logic r0);
    exp_t e;
    logic [63:0] bop;
    int n, off;
    bop    = (r0 && !up) ? 64'd0 : b;
    e.ea   = bop + (x << (int'(sh) + 1));
    n      = 1 << sz;
    off    = int'(e.ea[2:0]);
    e.inv  = (up && r0) || (rv && up) || (rv && sz == 2'd0);
    e.mis  = (off + n) > 8;
    e.is_err = e.inv || e.mis;
    e.addr = {e.ea[63:3], 3'b000};
    e.data = '0;
    e.strb = '0;
    e.wb   = up;
    for (int k = 0; k < n; k++) begin
      if (off + k < 8) begin
        e.strb[off + k] = 1'b1;
        e.data[8*(off + k) +: 8] = rv ? s[8*k +: 8] : s[8*(n - 1 - k) +: 8];
      end
    end
    return e;
  endfunction

  task automatic send(input logic [63:0] b, input logic [63:0] x, input logic [63:0] s,
                      input logic [1:0] sh, input logic [1:0] sz, input logic rv,
                      input logic up, input logic r0);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_base = b; req_index = x; req_src = s; req_shift = sh; req_size = sz;
    req_brev = rv; req_update = up; req_base_is_r0 = r0; req_valid = 1'b1;
    @(posedge clk);
    #1;
    q.push_back(model(b, x, s, sh, sz, rv, up, r0));
    req_valid = 1'b0;
    @(negedge clk);
    chk("R8 result due next cycle", {63'd0, mem_valid || err_valid}, 64'd1);
  endtask

  // memory back-pressure, changed away from both edges used for sampling
  initial forever begin
    @(posedge clk);
    #2;
    mem_ready = stall_en ? ($urandom_range(0, 2) != 0) : 1'b1;
  end

  // monitor / scoreboard
  logic        held = 1'b0;
  logic [63:0] h_addr, h_data;
  logic [7:0]  h_strb;
  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if (held) begin
        chk("R8 held valid", {63'd0, mem_valid}, 64'd1);
        chk("R8 held addr", mem_addr, h_addr);
        chk("R8 held data", mem_wdata, h_data);
        chk("R8 held strb", {56'd0, mem_strb}, {56'd0, h_strb});
      end
      held = mem_valid && !mem_ready;
      h_addr = mem_addr; h_data = mem_wdata; h_strb = mem_strb;
      if (wb_valid && !(mem_valid && mem_ready))
        chk("R9 stray writeback", 64'd1, 64'd0);
      if ((mem_valid && mem_ready) || err_valid) begin
        if (q.size() == 0) begin
          chk("R6 R7 unexpected output", 64'd1, 64'd0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk("R6 R7 error kind", {63'd0, err_valid}, {63'd0, e.is_err});
          if (err_valid) begin
            chk("R6 invalid flag", {63'd0, err_invalid}, {63'd0, e.inv});
            chk("R7 misaligned flag", {63'd0, err_misaligned}, {63'd0, e.mis});
            chk("R6 no write on error", {62'd0, mem_valid, wb_valid}, 64'd0);
          end else begin
            chk("R1 R2 R3 address", mem_addr, e.addr);
            chk("R3 strobes", {56'd0, mem_strb}, {56'd0, e.strb});
            chk("R4 R5 R11 lane data", mem_wdata, e.data);
            chk("R9 writeback strobe", {63'd0, wb_valid}, {63'd0, e.wb});
            if (e.wb) chk("R9 writeback address", wb_addr, e.ea);
          end
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R8 reset ready", {63'd0, req_ready}, 64'd1);
    chk("R8 reset idle", {61'd0, mem_valid, err_valid, wb_valid}, 64'd0);
    // R1 scaling for every shift, doubleword big-endian (R4)
    for (int sh = 0; sh < 4; sh++)
      send(64'h1000, 64'h10, 64'h0102030405060708, 2'(sh), 2'd3, 1'b0, 1'b0, 1'b0);
    // R1 wrap modulo 2^64
    send(64'hFFFF_FFFF_FFFF_FFF0, 64'h10, 64'hA1A2A3A4A5A6A7A8, 2'd0, 2'd3, 1'b0, 1'b0, 1'b0);
    // R2 base forced zero, and used by update form
    send(64'hDEAD_0000, 64'h3, 64'h11223344, 2'd1, 2'd2, 1'b0, 1'b0, 1'b1);
    send(64'h2004, 64'h1, 64'h5566, 2'd0, 2'd1, 1'b0, 1'b1, 1'b0);
    // R4 sub-doubleword sizes at offsets
    send(64'h3003, 64'h0, 64'hFFFF_FFFF_FFFF_FF5A, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0);
    send(64'h3006, 64'h0, 64'h0000_0000_0000_BEEF, 2'd0, 2'd1, 1'b0, 1'b0, 1'b0);
    // R5 reversed 2/4/8
    send(64'h4002, 64'h0, 64'h0000_0000_0000_1234, 2'd0, 2'd1, 1'b1, 1'b0, 1'b0);
    send(64'h4004, 64'h0, 64'h0000_0000_89AB_CDEF, 2'd0, 2'd2, 1'b1, 1'b0, 1'b0);
    send(64'h4000, 64'h0, 64'h0102030405060708, 2'd0, 2'd3, 1'b1, 1'b0, 1'b0);
    // R6 the three invalid encodings, R10 recovery
    send(64'h5000, 64'h8, 64'h1, 2'd0, 2'd3, 1'b0, 1'b1, 1'b1);
    send(64'h5000, 64'h8, 64'h1, 2'd0, 2'd3, 1'b1, 1'b1, 1'b0);
    send(64'h5000, 64'h8, 64'h1, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0);
    // R7 crossing a doubleword
    send(64'h6005, 64'h0, 64'h1, 2'd0, 2'd2, 1'b0, 1'b0, 1'b0);
    send(64'h6001, 64'h0, 64'h1, 2'd0, 2'd3, 1'b1, 1'b0, 1'b0);
    // sweep all combinations, with back-pressure in the second pass
    for (int pass = 0; pass < 2; pass++) begin
      stall_en = (pass == 1);
      for (int c = 0; c < 64; c++)
        send({$urandom, $urandom}, {32'd0, 29'd0, 3'($urandom)},
             {$urandom, $urandom}, 2'(c >> 2), 2'(c), c[4], c[5], c[3]);
    end
    stall_en = 1'b0;
    while (q.size() != 0 || mem_valid) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule